// File: doc/BRIEF.md
# ADC Interrupt Status With Limits

This block collects completion events from an ADC measurement path into six sticky status flags. Four flags record one-cycle strobes: new conversion result, spectral (DFT) result, supply-rejection filter result and temperature result. Each new conversion result is also compared against a programmable lower and upper limit. A result outside either limit sets its own sticky flag.

Software reads the flags through a small register port. It clears them by writing ones, and it selects which of them may raise the single interrupt line through an enable register. The interrupt line is the registered OR of every flag that is enabled.

Register map (2-bit address): 0 status (write-one-to-clear), 1 interrupt enable, 2 lower limit, 3 upper limit.

Top module: `adc_irq_status`

## Requirements
- R1: Status bits are assigned as follows: bit 0 result ready (`res_vld_i`), bit 1 DFT ready (`dft_rdy_i`), bit 2 filter ready (`flt_rdy_i`), bit 3 temperature ready (`tmp_rdy_i`), bit 4 below lower limit, bit 5 above upper limit. A strobe sampled high at a clock edge sets its bit, and the bit reads 1 from that edge on.
- R2: A write to address 0 clears every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R3: After reset the status, enable and lower limit registers read 0, the upper limit reads 0xFFFF and `irq_o` is 0.
- R4: Bit 5 sets only when a valid result is strictly greater than the upper limit at address 3. A result equal to the limit does not set it.
- R5: Bit 4 sets only when a valid result is strictly less than the lower limit at address 2. A result equal to the limit does not set it.
- R6: `irq_o` is 1 exactly one cycle after any status bit and the enable bit at the same position (address 1, bits 5:0) are both 1. A flag whose enable bit is 0 never raises `irq_o`.
- R7: When a set event and a clear write hit the same bit in one cycle, the bit ends up set.
- R8: Limit comparisons are unsigned on the 16-bit result and happen only while `res_vld_i` is high. Any value on `res_data_i` without the strobe leaves every flag unchanged.
- R9: Reading address 0 returns the flags in bits 5:0, and bits 15:6 read 0.
- R10: Addresses 1, 2 and 3 read back the last value written to them. The enable register holds bits 5:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational from `rd_addr_i` |
| res_vld_i | input | 1 | New conversion result strobe |
| res_data_i | input | 16 | Conversion result, unsigned |
| dft_rdy_i | input | 1 | DFT result ready strobe |
| flt_rdy_i | input | 1 | Filter result ready strobe |
| tmp_rdy_i | input | 1 | Temperature result ready strobe |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event strobes are synchronous to `clk_i` and may arrive together in any combination, including in the same cycle as a clear write. They also assume that `res_data_i` is meaningful only while `res_vld_i` is high. The stimulus changes every input half a cycle away from the rising edge and holds each strobe for exactly one cycle. It also places result values at each limit and one step beyond it on both sides, so every comparator decision is made on stable data.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int unsigned IRQ_N = 6;

  localparam int unsigned BIT_RES = 0;
  localparam int unsigned BIT_DFT = 1;
  localparam int unsigned BIT_FLT = 2;
  localparam int unsigned BIT_TMP = 3;
  localparam int unsigned BIT_LO  = 4;
  localparam int unsigned BIT_HI  = 5;

  typedef enum logic [1:0] {
    ADDR_STS = 2'd0,
    ADDR_EN  = 2'd1,
    ADDR_MIN = 2'd2,
    ADDR_MAX = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/adc_limit_cmp.sv
module adc_limit_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] lo_lim_i,
  input  logic [DATA_W-1:0] hi_lim_i,
  output logic              below_o,
  output logic              above_o
);
  always_comb begin
    below_o = vld_i && (data_i < lo_lim_i);
    above_o = vld_i && (data_i > hi_lim_i);
  end

  always_comb begin
    a_excl_r4: assert (!(below_o && above_o) || (lo_lim_i > hi_lim_i));
  end
endmodule

// File: rtl/adc_irq_sts_bank.sv
module adc_irq_sts_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[i] <= 1'b0;
      else if (set_i[i]) sts_q[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) sts_q[i] <= 1'b0;
    end
  end

  assign sts_o = sts_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((sts_q & $past(clr_i & ~set_i)) == '0));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(set_i | clr_i)) == ($past(sts_q) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/adc_irq_status.sv
module adc_irq_status
  import adc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              res_vld_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              dft_rdy_i,
  input  logic              flt_rdy_i,
  input  logic              tmp_rdy_i,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - IRQ_N;

  logic [IRQ_N-1:0]  en_q;
  logic [DATA_W-1:0] lo_lim_q, hi_lim_q;
  logic [IRQ_N-1:0]  sts, set_vec, clr_vec;
  logic              below, above, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      lo_lim_q <= '0;
      hi_lim_q <= '1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_EN:  en_q     <= wr_data_i[IRQ_N-1:0];
        ADDR_MIN: lo_lim_q <= wr_data_i;
        ADDR_MAX: hi_lim_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  adc_limit_cmp #(.DATA_W(DATA_W)) u_cmp (
    .vld_i    (res_vld_i),
    .data_i   (res_data_i),
    .lo_lim_i (lo_lim_q),
    .hi_lim_i (hi_lim_q),
    .below_o  (below),
    .above_o  (above)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_RES] = res_vld_i;
    set_vec[BIT_DFT] = dft_rdy_i;
    set_vec[BIT_FLT] = flt_rdy_i;
    set_vec[BIT_TMP] = tmp_rdy_i;
    set_vec[BIT_LO]  = below;
    set_vec[BIT_HI]  = above;
    clr_vec = (wr_en_i && wr_addr_i == ADDR_STS) ? wr_data_i[IRQ_N-1:0] : '0;
  end

  adc_irq_sts_bank #(.N(IRQ_N)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .sts_o  (sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts & en_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    case (rd_addr_i)
      ADDR_STS: rd_data_o = {{PAD_W{1'b0}}, sts};
      ADDR_EN:  rd_data_o = {{PAD_W{1'b0}}, en_q};
      ADDR_MIN: rd_data_o = lo_lim_q;
      default:  rd_data_o = hi_lim_q;
    endcase
  end

  p_above_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_i && res_data_i > hi_lim_q) |=> sts[BIT_HI]);

  p_below_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_i && res_data_i < lo_lim_q) |=> sts[BIT_LO]);

  p_no_lim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_vld_i && clr_vec == '0 && !sts[BIT_LO] && !sts[BIT_HI]) |=>
      (!sts[BIT_LO] && !sts[BIT_HI]));

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(sts & en_q) != '0)));
endmodule

// File: tb/adc_irq_status_test.sv
module adc_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        res_vld = 1'b0;
  logic [15:0] res_data = '0;
  logic        dft = 1'b0, flt = 1'b0, tmp = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  adc_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .res_vld_i(res_vld), .res_data_i(res_data),
    .dft_rdy_i(dft), .flt_rdy_i(flt), .tmp_rdy_i(tmp),
    .irq_o(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic result(input logic [15:0] v);
    @(negedge clk);
    res_vld = 1'b1; res_data = v;
    @(negedge clk);
    res_vld = 1'b0;
  endtask

  task automatic clear_all();
    wr(2'd0, 16'h003F);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R3 status", d, 16'h0);
    rd(2'd1, d); check("R3 enable", d, 16'h0);
    rd(2'd2, d); check("R3 lower", d, 16'h0);
    rd(2'd3, d); check("R3 upper", d, 16'hFFFF);
    check("R3 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_strobes();
    logic [15:0] d;
    @(negedge clk); dft = 1'b1; @(negedge clk); dft = 1'b0;
    rd(2'd0, d); check("R1 dft bit1", d, 16'h0002);
    clear_all();
    @(negedge clk); flt = 1'b1; @(negedge clk); flt = 1'b0;
    rd(2'd0, d); check("R1 filter bit2", d, 16'h0004);
    clear_all();
    @(negedge clk); tmp = 1'b1; @(negedge clk); tmp = 1'b0;
    rd(2'd0, d); check("R1 temp bit3", d, 16'h0008);
    clear_all();
    result(16'h1234);
    rd(2'd0, d); check("R1 result bit0", d, 16'h0001);
    clear_all();
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    @(negedge clk); dft = 1'b1; tmp = 1'b1; res_vld = 1'b1; res_data = 16'h10;
    @(negedge clk); dft = 1'b0; tmp = 1'b0; res_vld = 1'b0;
    rd(2'd0, d); check("R2 preset", d, 16'h000B);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); check("R2 zero write keeps", d, 16'h000B);
    wr(2'd0, 16'h0002);
    rd(2'd0, d); check("R2 clear bit1 only", d, 16'h0009);
    clear_all();
    rd(2'd0, d); check("R2 clear all", d, 16'h0000);
  endtask

  task automatic t_limits();
    logic [15:0] d;
    wr(2'd2, 16'd100);
    wr(2'd3, 16'd200);
    result(16'd200);
    rd(2'd0, d); check("R4 equal upper no flag", d, 16'h0001);
    clear_all();
    result(16'd201);
    rd(2'd0, d); check("R4 above upper", d, 16'h0021);
    clear_all();
    result(16'd100);
    rd(2'd0, d); check("R5 equal lower no flag", d, 16'h0001);
    clear_all();
    result(16'd99);
    rd(2'd0, d); check("R5 below lower", d, 16'h0011);
    clear_all();
    result(16'hFFFF);
    rd(2'd0, d); check("R8 unsigned max value", d, 16'h0021);
    clear_all();
  endtask

  task automatic t_novalid();
    logic [15:0] d;
    @(negedge clk); res_data = 16'd0;
    @(negedge clk); res_data = 16'hFFFF;
    @(negedge clk);
    rd(2'd0, d); check("R8 no strobe no flags", d, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    @(negedge clk); dft = 1'b1; @(negedge clk); dft = 1'b0;
    @(negedge clk);
    dft = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0002;
    @(negedge clk);
    dft = 1'b0; wr_en = 1'b0;
    rd(2'd0, d); check("R7 set wins", d, 16'h0002);
    clear_all();
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(2'd1, 16'h0004);
    @(negedge clk); dft = 1'b1; @(negedge clk); dft = 1'b0;
    @(negedge clk);
    check("R6 masked flag no irq", {15'b0, irq}, 16'h0);
    @(negedge clk); flt = 1'b1; @(negedge clk); flt = 1'b0;
    check("R6 irq one cycle late", {15'b0, irq}, 16'h0);
    @(negedge clk);
    check("R6 irq high", {15'b0, irq}, 16'h1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0004;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 irq lags clear", {15'b0, irq}, 16'h1);
    @(negedge clk);
    check("R6 irq drops", {15'b0, irq}, 16'h0);
    clear_all();
  endtask

  task automatic t_read();
    logic [15:0] d;
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R10 enable 6 bits", d, 16'h003F);
    wr(2'd2, 16'hA5A5);
    rd(2'd2, d); check("R10 lower readback", d, 16'hA5A5);
    wr(2'd3, 16'h5A5A);
    rd(2'd3, d); check("R10 upper readback", d, 16'h5A5A);
    @(negedge clk); dft = 1'b1; flt = 1'b1; tmp = 1'b1; res_vld = 1'b1; res_data = 16'h0000;
    @(negedge clk); dft = 1'b0; flt = 1'b0; tmp = 1'b0; res_vld = 1'b0;
    @(negedge clk); res_vld = 1'b1; res_data = 16'hFFFF;
    @(negedge clk); res_vld = 1'b0;
    rd(2'd0, d); check("R9 all flags, upper zero", d, 16'h003F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strobes();
    t_w1c();
    t_limits();
    t_novalid();
    t_collide();
    t_irq();
    t_read();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule